// File: doc/BRIEF.md
# Vector Buffer Address Generator

This block turns one vector buffer memory access into a byte address for every lane of a wavefront. Its inputs are a buffer resource descriptor, a scalar offset, an immediate offset taken from the instruction, a per-lane index and a per-lane offset, and the execution mask. The descriptor carries a base address, a stride, a record count, a swizzle enable, codes for the index stride and the element size, a thread-id enable and a format field. The block checks each active lane against the buffer bounds. It then returns the addresses, a mask of the lanes that are out of bounds, and the effective mask that the memory access should use. That mask is the execution mask with the out-of-bounds lanes removed.

In linear mode the buffer is an array of records, each record stride bytes long. In swizzled mode the index and the offset are split into blocks of a power-of-two size and interleaved, so neighbouring lanes land in neighbouring elements. Which bound rule applies depends on the raw stride field and on the swizzle enable, and this choice is made apart from the choice of address mode. A request comes in with a one-cycle input strobe. Exactly one cycle later all results appear in registers, together with a one-cycle output strobe.

Top module: `vbuf_addr_gen`

## Requirements
- R1: The cycle after a clock edge that samples `in_valid_i` high, `out_valid_o` is high for exactly one cycle. The results for that request are in the output registers at the same time. While `in_valid_i` is low, all result outputs hold their values.
- R2: The effective stride is `desc_fmt_i * 16384 + desc_stride_i` when `desc_tid_en_i` is 1. Otherwise it is `desc_stride_i`.
- R3: The buffer index of lane n is its index slice plus n when `desc_tid_en_i` is 1, and the index slice alone otherwise. The buffer offset of a lane is its offset slice plus `imm_off_i`. Lane n uses bits [n*W +: W] of each packed lane vector.
- R4: When `desc_swz_en_i` is 0, the address of an active lane is base + scalar offset + effective stride × buffer index + buffer offset, modulo 2^AW.
- R5: When `desc_swz_en_i` is 1, let B = 8 << `desc_idx_code_i` and E = 2 << `desc_elem_code_i`. The address of an active lane is base + scalar offset + ((index/B × effective stride + offset/E × E) × B + (index mod B) × E + offset mod E), modulo 2^AW.
- R6: When `desc_stride_i` is 0 or `desc_swz_en_i` is 0, an active lane is out of bounds if buffer offset + effective stride × buffer index + scalar offset ≥ record count. The comparison is exact, with no wrap.
- R7: When `desc_stride_i` is nonzero and `desc_swz_en_i` is 1, an active lane is out of bounds if its buffer index ≥ record count or if its buffer offset ≥ effective stride.
- R8: A lane whose `exec_i` bit is 0 gives address 0 and is never flagged out of bounds.
- R9: `eff_mask_o` equals the registered execution mask with the out-of-bounds lanes cleared. `exec_o` returns `exec_i` unchanged.
- R10: While reset is asserted, `out_valid_o`, all addresses and all masks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request strobe |
| desc_base_i | input | AW | Buffer base address |
| desc_stride_i | input | 14 | Raw record stride in bytes |
| desc_nrec_i | input | AW | Record count (bound limit) |
| desc_swz_en_i | input | 1 | Swizzled addressing enable |
| desc_idx_code_i | input | 2 | Index block code, block = 8 << code |
| desc_elem_code_i | input | 2 | Element size code, size = 2 << code |
| desc_tid_en_i | input | 1 | Add lane number to index, extend stride by format field |
| desc_fmt_i | input | 4 | Format field, upper part of the extended stride |
| soff_i | input | AW | Scalar offset |
| imm_off_i | input | IMMW | Instruction immediate offset |
| lane_idx_i | input | LANES*IDXW | Per-lane index, lane n in slice n |
| lane_off_i | input | LANES*OFFW | Per-lane offset, lane n in slice n |
| exec_i | input | LANES | Execution mask |
| out_valid_o | output | 1 | Result strobe |
| lane_addr_o | output | LANES*AW | Per-lane byte address |
| oob_o | output | LANES | Out-of-bounds lane mask |
| eff_mask_o | output | LANES | Execution mask with out-of-bounds lanes cleared |
| exec_o | output | LANES | Execution mask passed through |

## Verification
The hardest cases to reach from the ports are the ones where the address mode and the bound rule disagree. One is swizzle enabled with a raw stride of zero, where the address is swizzled but the linear bound applies. Another is thread-id enabled, where the effective stride differs from the raw field and the lane number feeds the bound. The stimulus table has entries built for exactly these cases. In them one lane's index would trip the other rule's bound and another lane's total lands exactly on the record count. Further entries put the immediate offset right at the limit, and give a scalar offset larger than the record count.

// File: rtl/vbag_pkg.sv
package vbag_pkg;
  localparam int STRIDE_W = 14;
  localparam int FMT_W    = 4;
  localparam int CODE_W   = 2;
  localparam int SHIFT_W  = 3;
  localparam int ESW      = STRIDE_W + FMT_W;

  typedef struct packed {
    logic               swz_addr;
    logic               swz_bound;
    logic [SHIFT_W-1:0] idx_shift;
    logic [SHIFT_W-1:0] elem_shift;
  } lane_ctl_t;
endpackage

// File: rtl/vbag_desc_dec.sv
module vbag_desc_dec
  import vbag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]       base_i,
  input  logic [AW-1:0]       soff_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [FMT_W-1:0]    fmt_i,
  input  logic                tid_en_i,
  input  logic                swz_en_i,
  input  logic [CODE_W-1:0]   idx_code_i,
  input  logic [CODE_W-1:0]   elem_code_i,
  output logic [ESW-1:0]      eff_stride_o,
  output logic [AW-1:0]       start_o,
  output lane_ctl_t           ctl_o
);
  always_comb begin
    // extended stride: the format field sits directly above the 14-bit stride
    eff_stride_o     = tid_en_i ? {fmt_i, stride_i} : ESW'(stride_i);
    start_o          = base_i + soff_i;
    ctl_o.swz_addr   = swz_en_i;
    ctl_o.swz_bound  = swz_en_i && (stride_i != '0);
    ctl_o.idx_shift  = SHIFT_W'(3) + SHIFT_W'(idx_code_i);
    ctl_o.elem_shift = SHIFT_W'(1) + SHIFT_W'(elem_code_i);
  end
endmodule

// File: rtl/vbag_lane.sv
module vbag_lane
  import vbag_pkg::*;
#(
  parameter int AW      = 32,
  parameter int IDXW    = 16,
  parameter int OFFW    = 16,
  parameter int IMMW    = 12,
  parameter int LANE_ID = 0
) (
  input  logic            active_i,
  input  logic            tid_en_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [ESW-1:0]  eff_stride_i,
  input  logic [AW-1:0]   start_i,
  input  logic [AW-1:0]   soff_i,
  input  logic [AW-1:0]   nrec_i,
  input  lane_ctl_t       ctl_i,
  output logic [AW-1:0]   addr_o,
  output logic            oob_o
);
  localparam int XW  = IDXW + 1;
  localparam int BW  = ((OFFW > IMMW) ? OFFW : IMMW) + 1;
  localparam int PW  = ESW + XW;
  localparam int CW  = ((PW > AW) ? PW : AW) + 2;

  logic [XW-1:0] buf_idx;
  logic [BW-1:0] buf_off;
  logic [CW-1:0] idx_w, off_w, str_w;
  logic [CW-1:0] lin_rel, swz_rel, rel;
  logic [CW-1:0] idx_q, idx_r, off_q, off_r, idx_mask, elem_mask;
  logic          lin_oob, swz_oob;

  always_comb begin
    buf_idx = XW'(idx_i) + (tid_en_i ? XW'(LANE_ID) : '0);
    buf_off = BW'(off_i) + BW'(imm_i);
    idx_w   = CW'(buf_idx);
    off_w   = CW'(buf_off);
    str_w   = CW'(eff_stride_i);

    // linear placement and its bound
    lin_rel = str_w * idx_w + off_w;
    lin_oob = (lin_rel + CW'(soff_i)) >= CW'(nrec_i);

    // swizzled placement: power-of-two splits become shifts and masks
    idx_mask  = (CW'(1) << ctl_i.idx_shift) - CW'(1);
    elem_mask = (CW'(1) << ctl_i.elem_shift) - CW'(1);
    idx_q     = idx_w >> ctl_i.idx_shift;
    idx_r     = idx_w & idx_mask;
    off_q     = off_w >> ctl_i.elem_shift;
    off_r     = off_w & elem_mask;
    swz_rel   = ((idx_q * str_w + (off_q << ctl_i.elem_shift)) << ctl_i.idx_shift)
              + (idx_r << ctl_i.elem_shift) + off_r;
    swz_oob   = (idx_w >= CW'(nrec_i)) || (off_w >= str_w);

    rel    = ctl_i.swz_addr ? swz_rel : lin_rel;
    addr_o = active_i ? (start_i + rel[AW-1:0]) : '0;
    oob_o  = active_i && (ctl_i.swz_bound ? swz_oob : lin_oob);
  end
endmodule

// File: rtl/vbuf_addr_gen.sv
module vbuf_addr_gen
  import vbag_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AW    = 32,
  parameter int IDXW  = 16,
  parameter int OFFW  = 16,
  parameter int IMMW  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid_i,
  input  logic [AW-1:0]         desc_base_i,
  input  logic [13:0]           desc_stride_i,
  input  logic [AW-1:0]         desc_nrec_i,
  input  logic                  desc_swz_en_i,
  input  logic [1:0]            desc_idx_code_i,
  input  logic [1:0]            desc_elem_code_i,
  input  logic                  desc_tid_en_i,
  input  logic [3:0]            desc_fmt_i,
  input  logic [AW-1:0]         soff_i,
  input  logic [IMMW-1:0]       imm_off_i,
  input  logic [LANES*IDXW-1:0] lane_idx_i,
  input  logic [LANES*OFFW-1:0] lane_off_i,
  input  logic [LANES-1:0]      exec_i,
  output logic                  out_valid_o,
  output logic [LANES*AW-1:0]   lane_addr_o,
  output logic [LANES-1:0]      oob_o,
  output logic [LANES-1:0]      eff_mask_o,
  output logic [LANES-1:0]      exec_o
);
  logic [ESW-1:0]      eff_stride;
  logic [AW-1:0]       start_addr;
  lane_ctl_t           ctl;
  logic [LANES*AW-1:0] addr_nx;
  logic [LANES-1:0]    oob_nx;

  vbag_desc_dec #(.AW(AW)) u_dec (
    .base_i      (desc_base_i),
    .soff_i      (soff_i),
    .stride_i    (desc_stride_i),
    .fmt_i       (desc_fmt_i),
    .tid_en_i    (desc_tid_en_i),
    .swz_en_i    (desc_swz_en_i),
    .idx_code_i  (desc_idx_code_i),
    .elem_code_i (desc_elem_code_i),
    .eff_stride_o(eff_stride),
    .start_o     (start_addr),
    .ctl_o       (ctl)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vbag_lane #(
      .AW(AW), .IDXW(IDXW), .OFFW(OFFW), .IMMW(IMMW), .LANE_ID(g)
    ) u_lane (
      .active_i    (exec_i[g]),
      .tid_en_i    (desc_tid_en_i),
      .idx_i       (lane_idx_i[g*IDXW +: IDXW]),
      .off_i       (lane_off_i[g*OFFW +: OFFW]),
      .imm_i       (imm_off_i),
      .eff_stride_i(eff_stride),
      .start_i     (start_addr),
      .soff_i      (soff_i),
      .nrec_i      (desc_nrec_i),
      .ctl_i       (ctl),
      .addr_o      (addr_nx[g*AW +: AW]),
      .oob_o       (oob_nx[g])
    );
  end

  logic                valid_q, valid_d;
  logic [LANES*AW-1:0] addr_q, addr_d;
  logic [LANES-1:0]    oob_q, oob_d, eff_q, eff_d, exec_q, exec_d;

  // next state: results load only under the input strobe
  always_comb begin
    valid_d = in_valid_i;
    addr_d  = addr_q;
    oob_d   = oob_q;
    eff_d   = eff_q;
    exec_d  = exec_q;
    if (in_valid_i) begin
      addr_d = addr_nx;
      oob_d  = oob_nx;
      eff_d  = exec_i & ~oob_nx;
      exec_d = exec_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      oob_q   <= '0;
      eff_q   <= '0;
      exec_q  <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      oob_q   <= oob_d;
      eff_q   <= eff_d;
      exec_q  <= exec_d;
    end
  end

  assign out_valid_o = valid_q;
  assign lane_addr_o = addr_q;
  assign oob_o       = oob_q;
  assign eff_mask_o  = eff_q;
  assign exec_o      = exec_q;
endmodule

// File: rtl/vbuf_addr_gen_chk.sv
module vbuf_addr_gen_chk #(
  parameter int LANES = 4,
  parameter int AW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid_i,
  input logic [LANES-1:0]    exec_i,
  input logic                out_valid_o,
  input logic [LANES*AW-1:0] lane_addr_o,
  input logic [LANES-1:0]    oob_o,
  input logic [LANES-1:0]    eff_mask_o,
  input logic [LANES-1:0]    exec_o
);
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(lane_addr_o) && $stable(oob_o) && $stable(eff_mask_o)));
  p_oob_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ((oob_o & ~exec_o) == '0));
  p_mask_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (((eff_mask_o | oob_o) == exec_o) && ((eff_mask_o & oob_o) == '0)));
  p_exec_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> (exec_o == $past(exec_i)));

  for (genvar g = 0; g < LANES; g++) begin : g_idle
    p_idle_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !exec_o[g]) |-> (lane_addr_o[g*AW +: AW] == '0));
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r10: assert (!out_valid_o && (oob_o == '0) && (eff_mask_o == '0));
    end
  end
endmodule

bind vbuf_addr_gen vbuf_addr_gen_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid_i (in_valid_i),
  .exec_i     (exec_i),
  .out_valid_o(out_valid_o),
  .lane_addr_o(lane_addr_o),
  .oob_o      (oob_o),
  .eff_mask_o (eff_mask_o),
  .exec_o     (exec_o)
);

// File: tb/vbuf_addr_gen_tb.sv
module vbuf_addr_gen_tb;
  localparam int LANES = 4;
  localparam int AW    = 32;
  localparam int NV    = 10;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] soff;
    logic [31:0] nrec;
    logic [13:0] stride;
    logic [3:0]  fmt;
    logic        swz;
    logic [1:0]  isc;
    logic [1:0]  esc;
    logic        tid;
    logic [11:0] imm;
    logic [63:0] idx;
    logic [63:0] off;
    logic [3:0]  exec;
    logic [3:0]  exp_oob;
  } vec_t;

  // base, soff, nrec, stride, fmt, swz, isc, esc, tid, imm, idx, off, exec, expected oob
  localparam vec_t TBL [NV] = '{
    // 0: linear, imm adds to offset (R3 R4)
    '{32'h1000, 32'h10, 32'h1000, 14'd16, 4'd0, 1'b0, 2'd0, 2'd0, 1'b0, 12'd4,
      64'h0003_0002_0001_0000, 64'h000C_0008_0004_0000, 4'hF, 4'h0},
    // 1: linear bound, lane2 sums exactly to the record count (R6)
    '{32'h0, 32'h20, 32'h100, 14'h40, 4'd0, 1'b0, 2'd0, 2'd0, 1'b0, 12'd0,
      64'h0004_0003_0002_0001, 64'h0000_0020_001F_0020, 4'hF, 4'hC},
    // 2: same with lane3 inactive (R8)
    '{32'h0, 32'h20, 32'h100, 14'h40, 4'd0, 1'b0, 2'd0, 2'd0, 1'b0, 12'd0,
      64'h0004_0003_0002_0001, 64'h0000_0020_001F_0020, 4'h7, 4'h4},
    // 3: thread id, extended stride 16388 (R2 R3)
    '{32'h0, 32'h0, 32'd49164, 14'd4, 4'd1, 1'b0, 2'd0, 2'd0, 1'b1, 12'd0,
      64'h0, 64'h0, 4'hF, 4'h8},
    // 4: swizzled, block 8, element 4, all in bounds (R5)
    '{32'h2000, 32'h0, 32'd100, 14'd16, 4'd0, 1'b1, 2'd0, 2'd1, 1'b0, 12'd0,
      64'h0009_0014_0003_0000, 64'h000F_0006_0005_0000, 4'hF, 4'h0},
    // 5: swizzled bound: index == count, offset == stride (R7)
    '{32'h2000, 32'h0, 32'd20, 14'd16, 4'd0, 1'b1, 2'd0, 2'd1, 1'b0, 12'd0,
      64'h0009_0014_000F_0000, 64'h0010_0006_000F_0000, 4'hF, 4'hC},
    // 6: swizzle on, raw stride 0: swizzled address, linear bound (R5 R6)
    '{32'h300, 32'h0, 32'd8, 14'd0, 4'd0, 1'b1, 2'd0, 2'd0, 1'b0, 12'd0,
      64'h0001_0002_0003_0009, 64'h0003_0008_0007_0000, 4'hF, 4'h4},
    // 7: swizzle with thread id, lane3 index reaches the count (R3 R7)
    '{32'h40, 32'h4, 32'd8, 14'd2, 4'd0, 1'b1, 2'd1, 2'd0, 1'b1, 12'd0,
      64'h0005_0005_0005_0005, 64'h0001_0001_0001_0001, 4'hF, 4'h8},
    // 8: scalar offset beyond the record count: all lanes out (R6)
    '{32'h0, 32'h200, 32'h100, 14'd4, 4'd0, 1'b0, 2'd0, 2'd0, 1'b0, 12'd0,
      64'h0, 64'h0, 4'hF, 4'hF},
    // 9: immediate puts lane1 exactly on the limit (R3 R6)
    '{32'h0, 32'h0, 32'h1000, 14'd0, 4'd0, 1'b0, 2'd0, 2'd0, 1'b0, 12'hFFF,
      64'h0, 64'h0000_0000_0001_0000, 4'hF, 4'h2}
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid_i = 1'b0;
  logic [AW-1:0]       desc_base_i = '0;
  logic [13:0]         desc_stride_i = '0;
  logic [AW-1:0]       desc_nrec_i = '0;
  logic                desc_swz_en_i = 1'b0;
  logic [1:0]          desc_idx_code_i = '0;
  logic [1:0]          desc_elem_code_i = '0;
  logic                desc_tid_en_i = 1'b0;
  logic [3:0]          desc_fmt_i = '0;
  logic [AW-1:0]       soff_i = '0;
  logic [11:0]         imm_off_i = '0;
  logic [63:0]         lane_idx_i = '0;
  logic [63:0]         lane_off_i = '0;
  logic [3:0]          exec_i = '0;
  logic                out_valid_o;
  logic [LANES*AW-1:0] lane_addr_o;
  logic [3:0]          oob_o, eff_mask_o, exec_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vbuf_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
    .desc_base_i(desc_base_i), .desc_stride_i(desc_stride_i),
    .desc_nrec_i(desc_nrec_i), .desc_swz_en_i(desc_swz_en_i),
    .desc_idx_code_i(desc_idx_code_i), .desc_elem_code_i(desc_elem_code_i),
    .desc_tid_en_i(desc_tid_en_i), .desc_fmt_i(desc_fmt_i),
    .soff_i(soff_i), .imm_off_i(imm_off_i),
    .lane_idx_i(lane_idx_i), .lane_off_i(lane_off_i), .exec_i(exec_i),
    .out_valid_o(out_valid_o), .lane_addr_o(lane_addr_o),
    .oob_o(oob_o), .eff_mask_o(eff_mask_o), .exec_o(exec_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // address model written from R2..R5 and R8
  function automatic logic [31:0] ref_addr(input vec_t v, input int l);
    logic [63:0] es, ix, bo, rel, bsz, esz;
    es = v.tid ? (64'(v.fmt) * 64'd16384 + 64'(v.stride)) : 64'(v.stride);
    ix = 64'(v.idx[l*16 +: 16]) + (v.tid ? 64'(l) : 64'd0);
    bo = 64'(v.off[l*16 +: 16]) + 64'(v.imm);
    if (!v.exec[l]) return 32'd0;
    if (v.swz) begin
      bsz = 64'd8 << v.isc;
      esz = 64'd2 << v.esc;
      rel = ((ix / bsz) * es + (bo / esz) * esz) * bsz + (ix % bsz) * esz + (bo % esz);
    end else begin
      rel = es * ix + bo;
    end
    return 32'(64'(v.base) + 64'(v.soff) + rel);
  endfunction

  task automatic drive(input vec_t v, input logic vld);
    desc_base_i      = v.base;
    soff_i           = v.soff;
    desc_nrec_i      = v.nrec;
    desc_stride_i    = v.stride;
    desc_fmt_i       = v.fmt;
    desc_swz_en_i    = v.swz;
    desc_idx_code_i  = v.isc;
    desc_elem_code_i = v.esc;
    desc_tid_en_i    = v.tid;
    imm_off_i        = v.imm;
    lane_idx_i       = v.idx;
    lane_off_i       = v.off;
    exec_i           = v.exec;
    in_valid_i       = vld;
  endtask

  task automatic run_vec(input vec_t v, input int n);
    string areq, oreq;
    areq = v.swz ? "R5" : "R4";
    if (v.tid) areq = {areq, " R2 R3"};
    else if (v.imm != 0) areq = {areq, " R3"};
    oreq = (v.swz && v.stride != 0) ? "R7" : "R6";
    @(negedge clk);
    drive(v, 1'b1);
    @(negedge clk);
    in_valid_i = 1'b0;
    chk(out_valid_o === 1'b1, "R1", $sformatf("vec %0d strobe", n), 64'(out_valid_o), 64'd1);
    for (int l = 0; l < LANES; l++) begin
      chk(lane_addr_o[l*AW +: AW] === ref_addr(v, l),
          v.exec[l] ? areq : "R8", $sformatf("vec %0d lane %0d addr", n, l),
          64'(lane_addr_o[l*AW +: AW]), 64'(ref_addr(v, l)));
    end
    chk(oob_o === v.exp_oob, oreq, $sformatf("vec %0d oob", n), 64'(oob_o), 64'(v.exp_oob));
    chk(eff_mask_o === (v.exec & ~v.exp_oob), "R9", $sformatf("vec %0d eff mask", n),
        64'(eff_mask_o), 64'(v.exec & ~v.exp_oob));
    chk(exec_o === v.exec, "R9", $sformatf("vec %0d exec pass", n), 64'(exec_o), 64'(v.exec));
    @(negedge clk);
    chk(out_valid_o === 1'b0, "R1", $sformatf("vec %0d strobe width", n), 64'(out_valid_o), 64'd0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    logic [LANES*AW-1:0] held_addr;
    logic [3:0] held_oob;
    // reset state (R10)
    drive(TBL[0], 1'b1);
    repeat (3) @(negedge clk);
    chk(out_valid_o === 1'b0, "R10", "reset strobe", 64'(out_valid_o), 64'd0);
    chk(lane_addr_o === '0, "R10", "reset addr", lane_addr_o[63:0], 64'd0);
    chk(oob_o === 4'h0, "R10", "reset oob", 64'(oob_o), 64'd0);
    chk(eff_mask_o === 4'h0, "R10", "reset eff mask", 64'(eff_mask_o), 64'd0);
    in_valid_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) run_vec(TBL[n], n);

    // hold while no strobe (R1): change every input, outputs must not move
    run_vec(TBL[4], 4);
    held_addr = lane_addr_o;
    held_oob  = oob_o;
    drive(TBL[8], 1'b0);
    repeat (3) @(negedge clk);
    chk(lane_addr_o === held_addr, "R1", "hold addr", lane_addr_o[63:0], held_addr[63:0]);
    chk(oob_o === held_oob, "R1", "hold oob", 64'(oob_o), 64'(held_oob));

    // all lanes idle on an out-of-range request (R8)
    v = TBL[8];
    v.exec = 4'h0;
    v.exp_oob = 4'h0;
    run_vec(v, 100);

    // back-to-back strobes: second result replaces the first (R1)
    @(negedge clk);
    drive(TBL[1], 1'b1);
    @(negedge clk);
    drive(TBL[5], 1'b1);
    @(negedge clk);
    in_valid_i = 1'b0;
    chk(out_valid_o === 1'b1, "R1", "back-to-back strobe", 64'(out_valid_o), 64'd1);
    chk(oob_o === TBL[5].exp_oob, "R7", "back-to-back oob", 64'(oob_o), 64'(TBL[5].exp_oob));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule